// File: doc/BRIEF.md
# Conditional Microprogram Sequencer

This block is the address-sequencing core of a microcoded control unit. It keeps a microprogram counter that addresses an external control store. The control store returns the microword for that address in the same cycle. On every clock edge the counter takes its next value from one of four sources: its own incremented value, a start address from an opcode lookup table, an address supplied from outside, or the branch-target field of the current microword.

A branch-control field in the microword has two parts. One part picks the source. The other part names a condition on the datapath flags N and Z. When the condition holds, the picked source is loaded. When it does not hold, the counter steps to the next sequential address. This lets a shared fetch routine dispatch to per-opcode routines, test flags, loop and return to fetch. The control-signal field of the microword is passed out to drive the datapath.

Top module: `uSeqCore`

## Requirements
- R1: A synchronous reset, sampled high at a rising clock edge, sets the microaddress to 0.
- R2: The microword is `{srcSel[1:0], cond[2:0], ctrl[CTRL_W-1:0], target[ADDR_W-1:0]}`, with the target in the least significant bits and srcSel in the top two bits.
- R3: The control-signal output equals the ctrl field of the microword currently presented, with no register in the path.
- R4: Condition codes 000, 110 and 111 never branch: the next microaddress is the current one plus 1, whatever srcSel, N and Z are.
- R5: Condition code 001 always takes the selected source. The srcSel values are 00 for current address plus 1, 01 for the lookup address, 10 for the external address and 11 for the target field.
- R6: Condition 010 takes the source only when N is 1, and condition 011 only when N is 0. Otherwise the counter goes to current plus 1.
- R7: Condition 100 takes the source only when Z is 1, and condition 101 only when Z is 0. Otherwise the counter goes to current plus 1.
- R8: The increment wraps modulo 2^ADDR_W, so the all-ones address is followed by 0.
- R9: A microword whose ctrl field is all zero still tests and branches in the same way; only the ctrl output is zero.
- R10: A fetch sequence that ends with an unconditional branch to srcSel 01 moves to the lookup address on the next cycle. A routine that ends with an unconditional branch to its target returns to the fetch start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| microWord | input | 5+CTRL_W+ADDR_W | Microword read from the control store at uAddr |
| flagN | input | 1 | Negative flag from the datapath |
| flagZ | input | 1 | Zero flag from the datapath |
| lookupAddr | input | ADDR_W | Start address from the opcode lookup table |
| extAddr | input | ADDR_W | Externally supplied address |
| uAddr | output | ADDR_W | Current microaddress (counter value) |
| ctrlOut | output | CTRL_W | Control-signal field of the current microword |

## Verification
The assertions assume that the microword, the flags and both address inputs are stable and known at every rising edge once reset has been released. They also assume that reset is the only way to force the counter. The bench changes its inputs only one time unit after an edge and holds them until the next edge. It sets up each starting address with an unconditional branch to the target field. It then sweeps every source select, every condition code and every flag pair, from several start addresses including the all-ones address. Finally it runs a small case-based control store through a fetch, a dispatch, flag tests and a return.

// File: rtl/uSeqPkg.sv
package uSeqPkg;

  typedef enum logic [1:0] {
    SRC_INC    = 2'b00,
    SRC_LOOKUP = 2'b01,
    SRC_EXT    = 2'b10,
    SRC_TARGET = 2'b11
  } srcSel_e;

  typedef enum logic [2:0] {
    COND_NEVER  = 3'b000,
    COND_ALWAYS = 3'b001,
    COND_NSET   = 3'b010,
    COND_NCLR   = 3'b011,
    COND_ZSET   = 3'b100,
    COND_ZCLR   = 3'b101,
    COND_RSV6   = 3'b110,
    COND_RSV7   = 3'b111
  } condCode_e;

  localparam int SEL_W  = 2;
  localparam int COND_W = 3;

  // strobes from the control decode to the address datapath
  typedef struct packed {
    logic    takeSrc;
    srcSel_e src;
  } seqStrobe_t;

endpackage

// File: rtl/uSeqControl.sv
module uSeqControl
  import uSeqPkg::*;
(
  input  srcSel_e    srcSel,
  input  condCode_e  condCode,
  input  logic       flagN,
  input  logic       flagZ,
  output seqStrobe_t strobe
);

  logic condMet;

  always_comb begin
    unique case (condCode)
      COND_ALWAYS: condMet = 1'b1;
      COND_NSET:   condMet = flagN;
      COND_NCLR:   condMet = ~flagN;
      COND_ZSET:   condMet = flagZ;
      COND_ZCLR:   condMet = ~flagZ;
      default:     condMet = 1'b0;
    endcase
  end

  always_comb begin
    strobe.takeSrc = condMet;
    strobe.src     = srcSel;
  end

endmodule

// File: rtl/uSeqDatapath.sv
module uSeqDatapath
  import uSeqPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic [ADDR_W-1:0] targetAddr,
  output logic [ADDR_W-1:0] uAddr
);

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] pcInc;
  logic [ADDR_W-1:0] srcAddr;
  logic [ADDR_W-1:0] nextAddr;

  assign pcInc = pcReg + ADDR_W'(1);

  always_comb begin
    unique case (strobe.src)
      SRC_LOOKUP: srcAddr = lookupAddr;
      SRC_EXT:    srcAddr = extAddr;
      SRC_TARGET: srcAddr = targetAddr;
      default:    srcAddr = pcInc;
    endcase
  end

  assign nextAddr = strobe.takeSrc ? srcAddr : pcInc;

  always_ff @(posedge clk) begin
    if (rst) pcReg <= '0;
    else     pcReg <= nextAddr;
  end

  assign uAddr = pcReg;

endmodule

// File: rtl/uSeqCore.sv
module uSeqCore
  import uSeqPkg::*;
#(
  parameter  int ADDR_W = 10,
  parameter  int CTRL_W = 16,
  localparam int WORD_W = SEL_W + COND_W + CTRL_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] microWord,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] uAddr,
  output logic [CTRL_W-1:0] ctrlOut
);

  localparam int CTRL_LO = ADDR_W;
  localparam int COND_LO = CTRL_LO + CTRL_W;
  localparam int SEL_LO  = COND_LO + COND_W;

  logic [ADDR_W-1:0] targetField;
  srcSel_e           selField;
  condCode_e         condField;
  seqStrobe_t        strobe;

  assign targetField = microWord[ADDR_W-1:0];
  assign ctrlOut     = microWord[COND_LO-1:CTRL_LO];
  assign condField   = condCode_e'(microWord[SEL_LO-1:COND_LO]);
  assign selField    = srcSel_e'(microWord[WORD_W-1:SEL_LO]);

  uSeqControl ctrl_i (
    .srcSel   (selField),
    .condCode (condField),
    .flagN    (flagN),
    .flagZ    (flagZ),
    .strobe   (strobe)
  );

  uSeqDatapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .lookupAddr (lookupAddr),
    .extAddr    (extAddr),
    .targetAddr (targetField),
    .uAddr      (uAddr)
  );

endmodule

// File: rtl/uSeqCoreChecker.sv
module uSeqCoreChecker #(
  parameter  int ADDR_W = 10,
  parameter  int CTRL_W = 16,
  localparam int WORD_W = 5 + CTRL_W + ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] microWord,
  input logic              flagN,
  input logic              flagZ,
  input logic [ADDR_W-1:0] lookupAddr,
  input logic [ADDR_W-1:0] extAddr,
  input logic [ADDR_W-1:0] uAddr,
  input logic [CTRL_W-1:0] ctrlOut
);

  logic [1:0] selBits;
  logic [2:0] condBits;
  logic [ADDR_W-1:0] tgtBits;

  assign selBits  = microWord[WORD_W-1 -: 2];
  assign condBits = microWord[WORD_W-3 -: 3];
  assign tgtBits  = microWord[ADDR_W-1:0];

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (uAddr == '0));

  assert_no_branch_R4: assert property (@(posedge clk) disable iff (rst)
    (condBits == 3'b000 || condBits == 3'b110 || condBits == 3'b111)
      |=> (uAddr == ADDR_W'($past(uAddr) + 1'b1)));

  assert_always_ext_R5: assert property (@(posedge clk) disable iff (rst)
    (condBits == 3'b001 && selBits == 2'b10) |=> (uAddr == $past(extAddr)));

  assert_always_lookup_R10: assert property (@(posedge clk) disable iff (rst)
    (condBits == 3'b001 && selBits == 2'b01) |=> (uAddr == $past(lookupAddr)));

  assert_n_fail_R6: assert property (@(posedge clk) disable iff (rst)
    (condBits == 3'b010 && !flagN) |=> (uAddr == ADDR_W'($past(uAddr) + 1'b1)));

  assert_z_taken_R7: assert property (@(posedge clk) disable iff (rst)
    (condBits == 3'b100 && flagZ && selBits == 2'b11) |=> (uAddr == $past(tgtBits)));

endmodule

bind uSeqCore uSeqCoreChecker #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .microWord  (microWord),
  .flagN      (flagN),
  .flagZ      (flagZ),
  .lookupAddr (lookupAddr),
  .extAddr    (extAddr),
  .uAddr      (uAddr),
  .ctrlOut    (ctrlOut)
);

// File: tb/uSeqCore_tb.sv
`timescale 1ns/1ps
module uSeqCore_tb_top;

  localparam int ADDR_W = 10;
  localparam int CTRL_W = 16;
  localparam int WORD_W = 5 + CTRL_W + ADDR_W;
  localparam logic [ADDR_W-1:0] LOOKUP_V = 10'd200;
  localparam logic [ADDR_W-1:0] EXT_V    = 10'd400;

  logic clk = 1'b0;
  logic rst;
  logic [WORD_W-1:0] microWord;
  logic [WORD_W-1:0] manualWord;
  logic romMode;
  logic flagN, flagZ;
  logic [ADDR_W-1:0] lookupAddr, extAddr;
  logic [ADDR_W-1:0] uAddr;
  logic [CTRL_W-1:0] ctrlOut;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  function automatic logic [WORD_W-1:0] mk(input logic [1:0] sel, input logic [2:0] cnd,
                                           input logic [CTRL_W-1:0] ctl,
                                           input logic [ADDR_W-1:0] tgt);
    return {sel, cnd, ctl, tgt};
  endfunction

  // small case-based control store for the sequence test (R10)
  function automatic logic [WORD_W-1:0] romWord(input logic [ADDR_W-1:0] a);
    case (a)
      10'd0:   return mk(2'b11, 3'b001, 16'h0000, 10'd100);
      10'd100: return mk(2'b00, 3'b000, 16'h0C31, 10'd0);
      10'd101: return mk(2'b00, 3'b000, 16'h4210, 10'd0);
      10'd102: return mk(2'b01, 3'b001, 16'h2100, 10'd0);
      10'd200: return mk(2'b10, 3'b100, 16'h0000, 10'd0);
      10'd201: return mk(2'b11, 3'b010, 16'h0008, 10'd300);
      10'd202: return mk(2'b11, 3'b001, 16'h8001, 10'd100);
      default: return '0;
    endcase
  endfunction

  always_comb microWord = romMode ? romWord(uAddr) : manualWord;

  uSeqCore dut_i (
    .clk(clk), .rst(rst), .microWord(microWord), .flagN(flagN), .flagZ(flagZ),
    .lookupAddr(lookupAddr), .extAddr(extAddr), .uAddr(uAddr), .ctrlOut(ctrlOut)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    step();
    rst = 1'b0;
  endtask

  function automatic logic condHolds(input logic [2:0] c, input logic n, input logic z);
    case (c)
      3'd1: return 1'b1;
      3'd2: return n;
      3'd3: return !n;
      3'd4: return z;
      3'd5: return !z;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #(10 * 150000);
    total++; fails++;
    $display("FAIL watchdog expired (all requirements)");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] starts [3];
    starts[0] = 10'd5; starts[1] = 10'd1023; starts[2] = 10'd300;
    romMode = 1'b0; flagN = 1'b0; flagZ = 1'b0;
    lookupAddr = LOOKUP_V; extAddr = EXT_V;
    manualWord = mk(2'b00, 3'b000, 16'h0000, 10'd0);
    rst = 1'b1;
    step(); step();
    check("R1 reset address", 32'(uAddr), 0);
    rst = 1'b0;

    // sweep: every select, condition and flag pair from several start addresses
    for (int s = 0; s < 3; s++) begin
      for (int sel = 0; sel < 4; sel++) begin
        for (int c = 0; c < 8; c++) begin
          for (int nz = 0; nz < 4; nz++) begin
            logic [ADDR_W-1:0] exp;
            logic [ADDR_W-1:0] src;
            logic [ADDR_W-1:0] tgt;
            logic [CTRL_W-1:0] ctl;
            tgt = 10'(37 * (sel + 1) + 3 * c + nz + 600);
            ctl = 16'((sel * 8 + c) * 4 + nz) ^ 16'hA5A5;
            if (c == 3 && nz == 0) ctl = '0;  // test-only word (R9)
            manualWord = mk(2'b11, 3'b001, 16'h0000, starts[s]);
            step();
            check("R5 setup jump to target", 32'(uAddr), 32'(starts[s]));
            flagN = nz[1]; flagZ = nz[0];
            lookupAddr = LOOKUP_V + 10'(c); extAddr = EXT_V + 10'(nz);
            manualWord = mk(2'(sel), 3'(c), ctl, tgt);
            #1;
            check("R3 ctrl field passthrough", 32'(ctrlOut), 32'(ctl));
            case (sel)
              0: src = starts[s] + 10'd1;
              1: src = lookupAddr;
              2: src = extAddr;
              default: src = tgt;
            endcase
            exp = condHolds(3'(c), nz[1], nz[0]) ? src : starts[s] + 10'd1;
            step();
            if (c == 0 || c > 5) check("R4 no-branch codes", 32'(uAddr), 32'(exp));
            else if (c == 1)     check("R5 unconditional select", 32'(uAddr), 32'(exp));
            else if (c < 4)      check("R6 N test", 32'(uAddr), 32'(exp));
            else                 check("R7 Z test", 32'(uAddr), 32'(exp));
            if (starts[s] == 10'd1023 && !condHolds(3'(c), nz[1], nz[0]))
              check("R8 wrap to zero", 32'(uAddr), 0);
            if (ctl == '0) check("R9 zero ctrl still branches", 32'(uAddr), 32'(exp));
            flagN = 1'b0; flagZ = 1'b0;
          end
        end
      end
    end

    // microprogram runs through the case-based store (R10)
    lookupAddr = LOOKUP_V; extAddr = EXT_V;
    romMode = 1'b1;
    begin
      int expA [8];
      expA = '{100, 101, 102, 200, 201, 202, 100, 101};
      flagN = 1'b0; flagZ = 1'b0;
      doReset();
      check("R1 reset before run", 32'(uAddr), 0);
      for (int i = 0; i < 8; i++) begin
        step();
        check("R10 fetch, dispatch, return", 32'(uAddr), 32'(expA[i]));
      end
    end
    begin
      int expB [6];
      expB = '{100, 101, 102, 200, 201, 300};
      flagN = 1'b1; flagZ = 1'b0;
      doReset();
      for (int i = 0; i < 6; i++) begin
        step();
        check("R6 N branch in program", 32'(uAddr), 32'(expB[i]));
      end
      step();
      check("R9 empty word steps on", 32'(uAddr), 301);
    end
    begin
      int expC [5];
      expC = '{100, 101, 102, 200, 400};
      flagN = 1'b0; flagZ = 1'b1;
      doReset();
      for (int i = 0; i < 5; i++) begin
        step();
        check("R7 Z branch to external", 32'(uAddr), 32'(expC[i]));
      end
    end
    check("R2 ctrl field of word 0 at 400", 32'(ctrlOut), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule